// File: doc/BRIEF.md
# Wrapping Burst Read Address Generator

This block supplies the byte address for every data byte of a continuous read from a serial NOR array. A load strobe captures a start address, and each next-byte strobe moves the current address one step on. The step is a plain increment over the whole array, or a wrap inside a naturally aligned window of 16, 32 or 64 bytes. The window is the aligned block that holds the start address, so the bits above it never change during the burst.

The effective start address depends on the address mode. In 4-byte mode the command supplies every bit, and the stored segment bit plays no part. In 3-byte mode the command supplies the low 24 bits, and a segment-select bit, held in a separate extended-address register, becomes bit 24. That bit chooses the lower or the upper half of the 256Mb array. The wrap mode is taken when the start address is loaded. Changes to the wrap-mode input during a burst have no effect.

Top module: `burst_addr_gen`

## Requirements
- R1: While reset is asserted and after it is released, with no strobe, the current address is 0.
- R2: A load in 4-byte mode (addr4_en=1) makes the current address equal the low 25 bits of start_addr one clock later. Start bits 31..25 and seg_hi are ignored.
- R3: A load in 3-byte mode (addr4_en=0) makes the current address {seg_hi, start_addr[23:0]} one clock later. Start bits 31..24 are ignored.
- R4: With wrap code 00 (16 bytes), each next-byte strobe increments bits 3..0 modulo 16 and leaves bits 24..4 unchanged. For example, 15 is followed by 0.
- R5: With wrap code 01 (32 bytes), each strobe increments bits 4..0 modulo 32 and leaves bits 24..5 unchanged. For example, 31 is followed by 0.
- R6: With wrap code 10 (64 bytes), each strobe increments bits 5..0 modulo 64 and leaves bits 24..6 unchanged.
- R7: With wrap code 11 (no wrap), each strobe adds 1 to the full 25-bit address, so 01FFFFFFh is followed by 0.
- R8: The wrap code is sampled only on a load. Changing wrap_sel without a load does not alter the stepping of the burst in progress.
- R9: When load and next-byte strobes are asserted in the same cycle, the load wins and the address becomes the new start.
- R10: With neither strobe asserted, the current address holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_addr | input | 32 | Start address from the read command |
| ld_start | input | 1 | Capture start address and wrap code |
| adv_byte | input | 1 | Step to the next byte address |
| wrap_sel | input | 2 | Wrap code: 00=16, 01=32, 10=64, 11=none |
| addr4_en | input | 1 | 1 = 4-byte addressing, 0 = 3-byte addressing |
| seg_hi | input | 1 | Segment-select bit used as bit 24 in 3-byte mode |
| rd_addr | output | 25 | Current byte address |

## Verification
The assertions assume that every input is stable and known around each rising clock edge. They also assume that start_addr, addr4_en and seg_hi are meaningful only in a cycle with a load. No ordering between the two strobes is assumed, because a load must take precedence over a next-byte strobe. The stimulus changes inputs only on falling clock edges. It sweeps every start offset within a 64-byte window for each wrapping mode, and it applies simultaneous strobes and wrap-code changes in the middle of a burst on purpose. The upper-bit checks in the assertions therefore see both legal stepping and load interruptions.

// File: rtl/bag_pkg.sv
package bag_pkg;
   typedef enum logic [1:0] {
      WRAP16    = 2'b00,
      WRAP32    = 2'b01,
      WRAP64    = 2'b10,
      WRAP_NONE = 2'b11
   } wrap_e;
endpackage

// File: rtl/bag_eff_addr.sv
module bag_eff_addr #(
   parameter int ADDR_W     = 32,
   parameter int ARRAY_BITS = 25,
   parameter int SEG_POS    = 24
) (
   input  logic [ADDR_W-1:0]     start_addr,
   input  logic                  addr4_en,
   input  logic                  seg_hi,
   output logic [ARRAY_BITS-1:0] eff_addr
);
   if (ADDR_W < ARRAY_BITS) begin : g_bad_w
      $error("start address narrower than array");
   end
   if (ARRAY_BITS != SEG_POS + 1) begin : g_bad_seg
      $error("segment bit must be the top array bit");
   end

   logic [ARRAY_BITS-1:0] full_form;
   logic [ARRAY_BITS-1:0] short_form;

   // Command supplies all bits; array only decodes the low ones.
   assign full_form  = start_addr[ARRAY_BITS-1:0];
   // Short form: register bit selects the half, command gives the rest.
   assign short_form = {seg_hi, start_addr[SEG_POS-1:0]};
   assign eff_addr   = addr4_en ? full_form : short_form;
endmodule

// File: rtl/bag_step.sv
module bag_step
   import bag_pkg::*;
#(
   parameter int ARRAY_BITS   = 25,
   parameter int MIN_WRAP_LG2 = 4
) (
   input  logic [ARRAY_BITS-1:0] cur,
   input  wrap_e                 wsel,
   output logic [ARRAY_BITS-1:0] nxt
);
   localparam int N_WRAP = 3;

   if (ARRAY_BITS <= MIN_WRAP_LG2 + N_WRAP) begin : g_bad_sz
      $error("array too small for largest wrap window");
   end

   logic [ARRAY_BITS-1:0] cand [N_WRAP+1];

   for (genvar k = 0; k < N_WRAP; k++) begin : g_wrap
      localparam int WB = MIN_WRAP_LG2 + k;
      assign cand[k] = {cur[ARRAY_BITS-1:WB],
                        cur[WB-1:0] + {{(WB-1){1'b0}}, 1'b1}};
   end
   assign cand[N_WRAP] = cur + {{(ARRAY_BITS-1){1'b0}}, 1'b1};

   assign nxt = cand[wsel];
endmodule

// File: rtl/burst_addr_gen.sv
module burst_addr_gen
   import bag_pkg::*;
#(
   parameter int ADDR_W       = 32,
   parameter int ARRAY_BITS   = 25,
   parameter int SEG_POS      = 24,
   parameter int MIN_WRAP_LG2 = 4
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic [ADDR_W-1:0]     start_addr,
   input  logic                  ld_start,
   input  logic                  adv_byte,
   input  logic [1:0]            wrap_sel,
   input  logic                  addr4_en,
   input  logic                  seg_hi,
   output logic [ARRAY_BITS-1:0] rd_addr
);
   localparam int TOP_WIN = MIN_WRAP_LG2 + 2;

   logic [ARRAY_BITS-1:0] cur_q, eff_start, step_addr;
   wrap_e                 wrap_q;

   bag_eff_addr #(
      .ADDR_W(ADDR_W), .ARRAY_BITS(ARRAY_BITS), .SEG_POS(SEG_POS)
   ) i_eff (
      .start_addr(start_addr), .addr4_en(addr4_en),
      .seg_hi(seg_hi), .eff_addr(eff_start)
   );

   bag_step #(
      .ARRAY_BITS(ARRAY_BITS), .MIN_WRAP_LG2(MIN_WRAP_LG2)
   ) i_step (
      .cur(cur_q), .wsel(wrap_q), .nxt(step_addr)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cur_q  <= '0;
         wrap_q <= WRAP_NONE;
      end else if (ld_start) begin
         cur_q  <= eff_start;
         wrap_q <= wrap_e'(wrap_sel);
      end else if (adv_byte) begin
         cur_q  <= step_addr;
      end
   end

   assign rd_addr = cur_q;

   p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (!ld_start && !adv_byte) |=> $stable(rd_addr));

   p_load4_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (ld_start && addr4_en) |=> rd_addr == $past(start_addr[ARRAY_BITS-1:0]));

   p_load3_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (ld_start && !addr4_en) |=>
         (rd_addr[SEG_POS-1:0] == $past(start_addr[SEG_POS-1:0]))
         && (rd_addr[SEG_POS] == $past(seg_hi)));

   p_win_upper_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (!ld_start && adv_byte && wrap_q != WRAP_NONE) |=>
         $stable(rd_addr[ARRAY_BITS-1:TOP_WIN]));

   p_win16_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (!ld_start && adv_byte && wrap_q == WRAP16) |=>
         $stable(rd_addr[ARRAY_BITS-1:MIN_WRAP_LG2]));

   p_linear_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (!ld_start && adv_byte && wrap_q == WRAP_NONE) |=>
         rd_addr == $past(rd_addr) + {{(ARRAY_BITS-1){1'b0}}, 1'b1});

   p_wrap_keep_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !ld_start |=> $stable(wrap_q));
endmodule

// File: tb/test_burst_addr_gen.sv
module test_burst_addr_gen;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [31:0] start_addr = '0;
   logic        ld_start = 1'b0;
   logic        adv_byte = 1'b0;
   logic [1:0]  wrap_sel = 2'b11;
   logic        addr4_en = 1'b1;
   logic        seg_hi = 1'b0;
   logic [24:0] rd_addr;

   int checks = 0;
   int failures = 0;

   burst_addr_gen i_burst_addr_gen (
      .clk(clk), .rst_n(rst_n), .start_addr(start_addr),
      .ld_start(ld_start), .adv_byte(adv_byte), .wrap_sel(wrap_sel),
      .addr4_en(addr4_en), .seg_hi(seg_hi), .rd_addr(rd_addr)
   );

   always #4 clk = ~clk;

   task automatic tick();
      @(negedge clk);
   endtask

   task automatic chk(input string req, input logic [24:0] exp);
      checks++;
      if (rd_addr !== exp) begin
         failures++;
         $display("FAIL %s actual=%h expected=%h", req, rd_addr, exp);
      end
   endtask

   task automatic load(input logic [31:0] a, input logic [1:0] w,
                       input logic m4, input logic s);
      start_addr = a; wrap_sel = w; addr4_en = m4; seg_hi = s;
      ld_start = 1'b1; adv_byte = 1'b0;
      tick();
      ld_start = 1'b0;
   endtask

   task automatic adv();
      adv_byte = 1'b1;
      tick();
      adv_byte = 1'b0;
   endtask

   function automatic logic [24:0] wexp(input logic [24:0] base,
                                        input int n, input int lg);
      logic [24:0] m;
      m = 25'((1 << lg) - 1);
      return (base & ~m) | ((base + 25'(n)) & m);
   endfunction

   initial begin
      #1_600_000;
      failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (3) tick();
      chk("R1 in reset", 25'h0);
      rst_n = 1'b1;
      tick();
      chk("R1 after reset", 25'h0);

      // R4 R5 R6: sweep every offset of a 64-byte window per wrap size
      for (int w = 0; w < 3; w++) begin
         for (int off = 0; off < 64; off++) begin
            logic [24:0] base;
            base = 25'h0ABCD40 + 25'(off);
            load({7'h00, base}, 2'(w), 1'b1, 1'b0);
            chk(w == 0 ? "R4 load" : (w == 1 ? "R5 load" : "R6 load"), base);
            for (int n = 1; n <= 70; n++) begin
               adv();
               chk(w == 0 ? "R4 step" : (w == 1 ? "R5 step" : "R6 step"),
                   wexp(base, n, 4 + w));
            end
         end
      end

      // document-style examples: 15 -> 0 (16), 31 -> 16 (16), 31 -> 0 (32)
      load(32'd15, 2'b00, 1'b1, 1'b0); adv(); chk("R4 15 to 0", 25'd0);
      load(32'd31, 2'b00, 1'b1, 1'b0); adv(); chk("R4 31 to 16", 25'd16);
      load(32'd31, 2'b01, 1'b1, 1'b0); adv(); chk("R5 31 to 0", 25'd0);

      // R7: linear with rollover at top of array
      load(32'h01FF_FFFD, 2'b11, 1'b1, 1'b0);
      chk("R7 load", 25'h1FFFFFD);
      for (int n = 1; n <= 6; n++) begin
         adv();
         chk("R7 rollover", 25'(32'h01FF_FFFD + n));
      end

      // R2: 4-byte mode ignores upper start bits and seg_hi
      load(32'hFE00_0010, 2'b11, 1'b1, 1'b1);
      chk("R2 4-byte", 25'h0000010);
      // R3: 3-byte mode uses seg_hi as bit 24
      load(32'hAB12_3456, 2'b11, 1'b0, 1'b1);
      chk("R3 seg high", 25'h1123456);
      load(32'hAB12_3456, 2'b11, 1'b0, 1'b0);
      chk("R3 seg low", 25'h0123456);
      load(32'h00FF_FFFF, 2'b01, 1'b0, 1'b1);
      chk("R3 top", 25'h1FFFFFF);
      adv();
      chk("R5 3-byte wrap", 25'h1FFFFE0);

      // R8: wrap code change mid-burst is ignored
      load(32'h0000_0035, 2'b00, 1'b1, 1'b0);
      wrap_sel = 2'b11;
      for (int n = 1; n <= 14; n++) begin
         adv();
         chk("R8 wrap kept", wexp(25'h35, n, 4));
      end

      // R9: load beats simultaneous advance
      start_addr = 32'h0000_1234; wrap_sel = 2'b11; addr4_en = 1'b1;
      ld_start = 1'b1; adv_byte = 1'b1;
      tick();
      ld_start = 1'b0; adv_byte = 1'b0;
      chk("R9 load priority", 25'h0001234);

      // R10: hold with no strobe, even while other inputs move
      for (int n = 0; n < 4; n++) begin
         start_addr = 32'h0F0F_0F0F ^ 32'(n); wrap_sel = 2'(n);
         seg_hi = n[0]; addr4_en = n[1];
         tick();
         chk("R10 hold", 25'h0001234);
      end
      adv();
      chk("R10 then step", 25'h0001235);

      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule